// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a watchdog timer behind a small 32-bit register bus. A down-counter loads from a programmable reload value and counts toward zero. Software keeps the system alive by writing a 16-bit key to a restart register, which reloads the counter. If the counter runs out, the block can drive a reset pulse of programmable length and polarity and raise a pending-interrupt flag. If a memory-controller reset is in progress at that moment, the block instead clears its control register and stays silent.

The control register reacts only to writes that flip its enable bit. Turning enable on loads the counter and starts it. Turning enable off stops it. The counter steps either on every bus clock or only on cycles where an external 1 MHz tick strobe is high. The reset-output register changes its polarity and drive-type bits only through magic codes in its top byte. Its pulse-width field takes the written data on every word write.

Top module: `keyed_wdog`

## Requirements
- R1: After reset the count and reload registers read 0x03EF1480, control reads 0, the reset-output register reads 0x000000FF, `wdt_rst_out` is 1 and `irq_pend` is 0.
- R2: Word reads at byte offset 0x00 return the live count, 0x04 the reload value, 0x0C control (bits 5:0, upper bits 0) and 0x18 the reset-output register. Offset 0x08 reads 0. Every other offset reads 0 and ignores writes. Writes to offset 0x00 are ignored.
- R3: A word write to 0x08 whose low 16 bits are 0x4755 loads the count from the reload value, whatever the upper bits hold. It also restarts counting if enable is set. Any other value has no effect.
- R4: A control write is stored only when its bit 0 differs from the stored enable bit. A 0-to-1 change loads the count from the reload value and starts counting. A 1-to-0 change stops counting, and the count then holds.
- R5: With control bit 4 clear the running counter decrements on every clock. With bit 4 set it decrements only on clocks where `tick_1mhz` is high.
- R6: Expiry occurs on the step on which a running count of 0 would decrement. After it the counter stops at 0. If control bit 1 is set and `mem_rst_in` is low, `wdt_rst_out` is at its active level for the next W steps, where W is the width field. The active level equals bit 31 of the reset-output register, and the idle level is its inverse.
- R7: `irq_pend` becomes 1 on an expiry while control bit 2 is set and `mem_rst_in` is low. A valid key write (R3) clears it.
- R8: On an expiry while `mem_rst_in` is high, control is cleared to 0, no pulse is produced and `irq_pend` is unchanged.
- R9: A reset-output write with top byte 0xA5 sets bit 31 and 0x5A clears it. Top byte 0xA8 sets bit 30 and 0x8A clears it. Any other top byte leaves bits 31 and 30 unchanged.
- R10: Every word write to 0x18 stores the low WIDTH_BITS data bits (default 20) as the width field. Bits 29 down to WIDTH_BITS read 0.
- R11: Accesses with `bus_size` other than 2 (word) or with a nonzero `bus_addr[1:0]` leave all registers unchanged and read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, also the fast count source |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Access strobe, one cycle per access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset |
| bus_size | input | 2 | 0 byte, 1 halfword, 2 word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| tick_1mhz | input | 1 | Slow count strobe, one clock wide |
| mem_rst_in | input | 1 | Memory-controller reset in progress |
| wdt_rst_out | output | 1 | Reset pulse output |
| irq_pend | output | 1 | Timeout interrupt pending |

## Verification
The assertions assume that a control write does not arrive on the same cycle as an expiry that `mem_rst_in` suppresses. When both happen together, the write wins. They also assume that `tick_1mhz` lasts only one clock. The stimulus follows both rules. It changes control only while the counter is stopped or far from zero, and it raises the tick strobe for single cycles. Each access holds `bus_valid` for exactly one clock, so every write lands on a known edge.

// File: rtl/keyed_wdog_pkg.sv
package keyed_wdog_pkg;
    localparam logic [7:0]  OFS_COUNT  = 8'h00;
    localparam logic [7:0]  OFS_RELOAD = 8'h04;
    localparam logic [7:0]  OFS_KICK   = 8'h08;
    localparam logic [7:0]  OFS_CTRL   = 8'h0C;
    localparam logic [7:0]  OFS_OUTCFG = 8'h18;
    localparam logic [15:0] KICK_KEY   = 16'h4755;
    localparam logic [7:0]  MG_HIGH    = 8'hA5;
    localparam logic [7:0]  MG_LOW     = 8'h5A;
    localparam logic [7:0]  MG_PUSH    = 8'hA8;
    localparam logic [7:0]  MG_DRAIN   = 8'h8A;
    localparam logic [1:0]  SZ_WORD    = 2'd2;

    typedef struct packed {
        logic mode_full;
        logic slow_tick;
        logic ext_sig;
        logic irq_en;
        logic rst_en;
        logic en;
    } ctrl_t;

    typedef struct packed {
        logic act_high;
        logic push_pull;
    } drive_t;

    function automatic drive_t apply_magic(drive_t cur, logic [7:0] top);
        drive_t nxt = cur;
        case (top)
            MG_HIGH:  nxt.act_high  = 1'b1;
            MG_LOW:   nxt.act_high  = 1'b0;
            MG_PUSH:  nxt.push_pull = 1'b1;
            MG_DRAIN: nxt.push_pull = 1'b0;
            default:  nxt = cur;
        endcase
        return nxt;
    endfunction
endpackage

// File: rtl/keyed_wdog_regs.sv
module keyed_wdog_regs
    import keyed_wdog_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int CNT_W      = 32,
    parameter int WIDTH_BITS = 20,
    parameter logic [CNT_W-1:0] RELOAD_RST = 32'h03EF1480
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  bus_valid,
    input  logic                  bus_write,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [1:0]            bus_size,
    input  logic [31:0]           bus_wdata,
    input  logic [CNT_W-1:0]      count,
    input  logic                  expire,
    input  logic                  mem_rst_in,
    output ctrl_t                 ctrl,
    output logic [CNT_W-1:0]      reload,
    output drive_t                drv,
    output logic [WIDTH_BITS-1:0] width_q,
    output logic                  kick,
    output logic                  start,
    output logic                  stop,
    output logic [31:0]           bus_rdata
);
    localparam int PAD_W = 30 - WIDTH_BITS;

    logic word_ok, wr, wr_ctrl_acc;

    assign word_ok     = bus_valid && (bus_size == SZ_WORD) && (bus_addr[1:0] == 2'b00);
    assign wr          = word_ok && bus_write;
    assign wr_ctrl_acc = wr && (bus_addr == ADDR_W'(OFS_CTRL)) && (bus_wdata[0] != ctrl.en);
    assign start       = wr_ctrl_acc && bus_wdata[0];
    assign stop        = wr_ctrl_acc && !bus_wdata[0];
    assign kick        = wr && (bus_addr == ADDR_W'(OFS_KICK)) && (bus_wdata[15:0] == KICK_KEY);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl    <= '0;
            reload  <= RELOAD_RST;
            drv     <= '0;
            width_q <= WIDTH_BITS'(255);
        end else begin
            if (wr_ctrl_acc)
                ctrl <= ctrl_t'(bus_wdata[5:0]);
            else if (expire && mem_rst_in)
                ctrl <= '0;
            if (wr && bus_addr == ADDR_W'(OFS_RELOAD))
                reload <= CNT_W'(bus_wdata);
            if (wr && bus_addr == ADDR_W'(OFS_OUTCFG)) begin
                drv     <= apply_magic(drv, bus_wdata[31:24]);
                width_q <= bus_wdata[WIDTH_BITS-1:0];
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (word_ok && !bus_write) begin
            case (bus_addr)
                ADDR_W'(OFS_COUNT):  bus_rdata = 32'(count);
                ADDR_W'(OFS_RELOAD): bus_rdata = 32'(reload);
                ADDR_W'(OFS_CTRL):   bus_rdata = {26'd0, ctrl};
                ADDR_W'(OFS_OUTCFG): bus_rdata = {drv.act_high, drv.push_pull, {PAD_W{1'b0}}, width_q};
                default:             bus_rdata = '0;
            endcase
        end
    end

    assert_reject_narrow_R11: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && bus_write && bus_size != SZ_WORD && !(expire && mem_rst_in))
        |=> ($stable(ctrl) && $stable(reload) && $stable(width_q) && $stable(drv)));

    assert_suppress_clears_R8: assert property (@(posedge clk) disable iff (rst)
        (expire && mem_rst_in && !wr_ctrl_acc) |=> (ctrl == '0));
endmodule

// File: rtl/keyed_wdog_cnt.sv
module keyed_wdog_cnt #(
    parameter int CNT_W = 32,
    parameter logic [CNT_W-1:0] RST_VAL = 32'h03EF1480
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step_ok,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             arm,
    input  logic             halt,
    output logic [CNT_W-1:0] count,
    output logic             run,
    output logic             expire
);
    logic step;

    assign step   = run && step_ok && !load && !halt;
    assign expire = step && (count == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= RST_VAL;
            run   <= 1'b0;
        end else begin
            if (load)
                count <= load_val;
            else if (step && count != '0)
                count <= count - 1'b1;
            if (halt)
                run <= 1'b0;
            else if (arm)
                run <= 1'b1;
            else if (expire)
                run <= 1'b0;
        end
    end

    assert_hold_when_idle_R4: assert property (@(posedge clk) disable iff (rst)
        (!run && !load) |=> $stable(count));

    assert_stop_after_expire_R6: assert property (@(posedge clk) disable iff (rst)
        (expire && !arm) |=> (!run && count == '0));
endmodule

// File: rtl/keyed_wdog_pulse.sv
module keyed_wdog_pulse #(
    parameter int WIDTH_BITS = 20
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  fire,
    input  logic [WIDTH_BITS-1:0] width,
    input  logic                  step_ok,
    input  logic                  act_high,
    output logic                  active,
    output logic                  rst_out
);
    logic [WIDTH_BITS-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst)
            remain <= '0;
        else if (fire)
            remain <= width;
        else if (step_ok && remain != '0)
            remain <= remain - 1'b1;
    end

    assign active  = (remain != '0);
    assign rst_out = active ? act_high : !act_high;

    assert_pulse_after_fire_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(active) |-> $past(fire));

    assert_pulse_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (active && !step_ok && !fire) |=> $stable(remain));
endmodule

// File: rtl/keyed_wdog.sv
module keyed_wdog
    import keyed_wdog_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int CNT_W      = 32,
    parameter int WIDTH_BITS = 20,
    parameter logic [CNT_W-1:0] RELOAD_RST = 32'h03EF1480
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [1:0]        bus_size,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              tick_1mhz,
    input  logic              mem_rst_in,
    output logic              wdt_rst_out,
    output logic              irq_pend
);
    ctrl_t                 ctrl;
    drive_t                drv;
    logic [CNT_W-1:0]      reload, count;
    logic [WIDTH_BITS-1:0] width_q;
    logic kick, start, stop, run, expire, step_ok, fire, active;

    assign step_ok = ctrl.slow_tick ? tick_1mhz : 1'b1;
    assign fire    = expire && !mem_rst_in && ctrl.rst_en;

    keyed_wdog_regs #(
        .ADDR_W(ADDR_W), .CNT_W(CNT_W), .WIDTH_BITS(WIDTH_BITS), .RELOAD_RST(RELOAD_RST)
    ) u_regs (
        .clk(clk), .rst(rst),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
        .bus_size(bus_size), .bus_wdata(bus_wdata),
        .count(count), .expire(expire), .mem_rst_in(mem_rst_in),
        .ctrl(ctrl), .reload(reload), .drv(drv), .width_q(width_q),
        .kick(kick), .start(start), .stop(stop), .bus_rdata(bus_rdata)
    );

    keyed_wdog_cnt #(.CNT_W(CNT_W), .RST_VAL(RELOAD_RST)) u_cnt (
        .clk(clk), .rst(rst), .step_ok(step_ok),
        .load(kick || start), .load_val(reload),
        .arm(start || (kick && ctrl.en)), .halt(stop),
        .count(count), .run(run), .expire(expire)
    );

    keyed_wdog_pulse #(.WIDTH_BITS(WIDTH_BITS)) u_pulse (
        .clk(clk), .rst(rst), .fire(fire), .width(width_q),
        .step_ok(step_ok), .act_high(drv.act_high),
        .active(active), .rst_out(wdt_rst_out)
    );

    always_ff @(posedge clk) begin
        if (rst)
            irq_pend <= 1'b0;
        else if (expire && !mem_rst_in && ctrl.irq_en)
            irq_pend <= 1'b1;
        else if (kick)
            irq_pend <= 1'b0;
    end

    assert_irq_cause_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_pend) |-> $past(expire && !mem_rst_in && ctrl.irq_en));

    assert_no_pulse_suppressed_R8: assert property (@(posedge clk) disable iff (rst)
        (expire && mem_rst_in && !active) |=> !active);
endmodule

// File: tb/keyed_wdog_bench.sv
module keyed_wdog_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_valid = 1'b0, bus_write = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [1:0]  bus_size = 2'd2;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        tick_1mhz = 1'b0, mem_rst_in = 1'b0;
    logic        wdt_rst_out, irq_pend;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #5 clk = ~clk;

    keyed_wdog u_keyed_wdog (
        .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .tick_1mhz(tick_1mhz), .mem_rst_in(mem_rst_in),
        .wdt_rst_out(wdt_rst_out), .irq_pend(irq_pend)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [1:0] sz = 2'd2);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d; bus_size = sz;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0; bus_size = 2'd2;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d, input logic [1:0] sz = 2'd2);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a; bus_size = sz;
        #1 d = bus_rdata;
        bus_valid = 1'b0; bus_size = 2'd2;
    endtask

    initial begin
        logic [31:0] v;
        logic [31:0] exp_cnt;
        logic        exp_act;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        rd(8'h00, v); chk(v, 32'h03EF1480, "R1 count");
        rd(8'h04, v); chk(v, 32'h03EF1480, "R1 reload");
        rd(8'h0C, v); chk(v, 32'h0, "R1 ctrl");
        rd(8'h18, v); chk(v, 32'h000000FF, "R1 outcfg");
        chk(32'(wdt_rst_out), 32'd1, "R1 rst_out");
        chk(32'(irq_pend), 32'd0, "R1 irq");

        // R2 map corners
        rd(8'h08, v); chk(v, 32'h0, "R2 kick reads 0");
        wr(8'h10, 32'hFFFF_FFFF); rd(8'h10, v); chk(v, 32'h0, "R2 unknown offset");
        wr(8'h00, 32'h0000_0005); rd(8'h00, v); chk(v, 32'h03EF1480, "R2 count read-only");

        // R11 narrow and misaligned
        wr(8'h04, 32'h0000_1234, 2'd0); rd(8'h04, v); chk(v, 32'h03EF1480, "R11 byte write");
        wr(8'h05, 32'h0000_1234);        rd(8'h04, v); chk(v, 32'h03EF1480, "R11 misaligned");
        rd(8'h04, v, 2'd1); chk(v, 32'h0, "R11 halfword read");

        // R10 width field
        wr(8'h18, 32'hFFFF_FFFF); rd(8'h18, v); chk(v, 32'h000F_FFFF, "R10 width field");

        // R6/R7 sweep over reload and width
        for (int r = 1; r <= 4; r++) begin
            for (int w = 1; w <= 3; w++) begin
                wr(8'h18, 32'(w));
                wr(8'h04, 32'(r));
                wr(8'h0C, 32'h07);
                for (int k = 0; k <= r + w + 2; k++) begin
                    exp_cnt = (k <= r) ? 32'(r - k) : 32'd0;
                    exp_act = (k >= r + 1) && (k <= r + w);
                    rd(8'h00, v); chk(v, exp_cnt, $sformatf("R6 count r=%0d w=%0d k=%0d", r, w, k));
                    chk(32'(wdt_rst_out), 32'(!exp_act), $sformatf("R6 pulse r=%0d w=%0d k=%0d", r, w, k));
                    chk(32'(irq_pend), 32'(k >= r + 1), $sformatf("R7 irq r=%0d w=%0d k=%0d", r, w, k));
                    @(negedge clk);
                end
                wr(8'h0C, 32'h00);
                wr(8'h08, 32'h0000_4755);
                chk(32'(irq_pend), 32'd0, "R7 irq cleared by key");
                rd(8'h00, v); chk(v, 32'(r), "R3 key loads count");
            end
        end

        // R3/R4 key and enable-edge behaviour
        wr(8'h04, 32'd10);
        wr(8'h0C, 32'h01);
        rd(8'h00, v); chk(v, 32'd10, "R4 enable loads reload");
        repeat (3) @(negedge clk);
        rd(8'h00, v); chk(v, 32'd7, "R5 fast step");
        wr(8'h08, 32'h0000_4756);
        rd(8'h00, v); chk(v, 32'd5, "R3 bad key ignored");
        wr(8'h08, 32'hABCD_4755);
        rd(8'h00, v); chk(v, 32'd10, "R3 key with upper bits");
        wr(8'h0C, 32'h07);
        rd(8'h0C, v); chk(v, 32'h01, "R4 same-enable write dropped");
        wr(8'h0C, 32'h00);
        rd(8'h00, v); exp_cnt = v;
        repeat (3) @(negedge clk);
        rd(8'h00, v); chk(v, exp_cnt, "R4 count holds when stopped");
        wr(8'h0C, 32'h02);
        rd(8'h0C, v); chk(v, 32'h0, "R4 write while disabled dropped");

        // R5 slow tick
        wr(8'h04, 32'd4);
        wr(8'h0C, 32'h11);
        repeat (3) @(negedge clk);
        rd(8'h00, v); chk(v, 32'd4, "R5 no tick no step");
        tick_1mhz = 1'b1; @(negedge clk); tick_1mhz = 1'b0;
        rd(8'h00, v); chk(v, 32'd3, "R5 one tick one step");
        wr(8'h0C, 32'h10);

        // R8 suppression
        mem_rst_in = 1'b1;
        wr(8'h18, 32'd3);
        wr(8'h04, 32'd1);
        wr(8'h0C, 32'h07);
        for (int k = 0; k < 6; k++) begin
            chk(32'(wdt_rst_out), 32'd1, $sformatf("R8 no pulse k=%0d", k));
            @(negedge clk);
        end
        rd(8'h0C, v); chk(v, 32'h0, "R8 ctrl cleared");
        chk(32'(irq_pend), 32'd0, "R8 no irq");
        mem_rst_in = 1'b0;

        // R9 magic codes and active-high pulse
        wr(8'h18, 32'hA500_0002); rd(8'h18, v); chk(v, 32'h8000_0002, "R9 active high");
        wr(8'h18, 32'hA800_0002); rd(8'h18, v); chk(v, 32'hC000_0002, "R9 push pull");
        wr(8'h18, 32'h1200_0003); rd(8'h18, v); chk(v, 32'hC000_0003, "R9 other top byte");
        wr(8'h18, 32'h8A00_0003); rd(8'h18, v); chk(v, 32'h8000_0003, "R9 open drain");
        chk(32'(wdt_rst_out), 32'd0, "R6 idle level inverted");
        wr(8'h04, 32'd1);
        wr(8'h0C, 32'h03);
        for (int k = 0; k <= 6; k++) begin
            chk(32'(wdt_rst_out), 32'((k >= 2) && (k <= 4)), $sformatf("R6 high pulse k=%0d", k));
            @(negedge clk);
        end
        wr(8'h0C, 32'h00);
        wr(8'h18, 32'h5A00_0000); rd(8'h18, v); chk(v, 32'h0, "R9 active low");

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #1_500_000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule